// File: doc/BRIEF.md
# Three-Port Bank Access Arbiter

This block sits between three serial-bus slave front ends and a pair of 256-byte memory banks. It decides which front end may answer its bus in any cycle. Bank port 1 serves only the first bank and bank port 2 serves only the second. The control port sees both banks as a single 512-byte space and picks a bank with its top address bit. Each front end raises a request for as long as it has a transaction. It gives the read/write direction at the same time, and it pulses a finish strobe when the transaction closes, either with a stop or with a missing acknowledge after a sequential read.

Read sessions on the two bank ports may overlap, each at its own address. A write session on any port, or any control-port session, keeps every other port off its bus. When a write session closes, the block times the internal programming interval with a parameterised cycle counter. No port is granted until that count has elapsed, which lets a bus master poll for the acknowledge. The block also records whether the last sessions ran in per-bank mode or in combined mode. It keeps one pointer-valid flag per port and clears the flags of the mode being left whenever the mode changes.

Top module: `bank_port_arbiter`

## Requirements
- R1: After reset, all three grants, `wr_busy`, `comb_mode`, `cp_bank_en` and all three pointer-valid flags are 0.
- R2: When a request meets no conflicting session and no busy condition, its grant rises at the next clock edge. The grant stays high until the edge that samples that port's finish strobe, and falls at that edge. The read/write level is taken at grant time (1 = write).
- R3: Read requests on both bank ports are both granted. They may start together or overlap in time.
- R4: While a bank port holds a write session, the other bank port and the control port are not granted. A bank port asking to write is not granted while the other bank port holds a session. If both bank ports ask in the same cycle and either asks to write, only bank port 1 is granted.
- R5: While the control port holds a session, neither bank port is granted. The control port is not granted while any bank port holds a session.
- R6: If the control port and a bank port ask in the same cycle and no session is active, the control port is granted.
- R7: At the edge that samples the finish strobe of a write session, `wr_busy` rises. It stays high for exactly WR_CYCLES cycles.
- R8: No new grant is given at an edge where `wr_busy` or `eng_busy` is high before the edge, nor at the edge that closes a write session. A request held through that time is granted at the first edge after both are low.
- R9: `cp_bank_en` is 0 while the control port has no grant. While it has a grant, `cp_bank_en` is 2'b10 (second bank) when `cp_hi_bank` is 1, and 2'b01 (first bank) when `cp_hi_bank` is 0.
- R10: `comb_mode` becomes 1 at the edge that grants a control-port session, and 0 at the edge that grants a bank-port session. It changes at no other time.
- R11: A port's pointer-valid flag is set at the edge that ends that port's session. When the mode changes, the flags of the mode being left are cleared. If a flag would be set and cleared at the same edge, clearing wins.
- R12: Ending a read session does not raise `wr_busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| b1_req | input | 1 | Bank port 1 has a transaction |
| b1_wr | input | 1 | Bank port 1 direction, 1 = write |
| b1_fin | input | 1 | Bank port 1 transaction finished (one-cycle pulse) |
| b2_req | input | 1 | Bank port 2 has a transaction |
| b2_wr | input | 1 | Bank port 2 direction, 1 = write |
| b2_fin | input | 1 | Bank port 2 transaction finished |
| cp_req | input | 1 | Control port has a transaction |
| cp_wr | input | 1 | Control port direction, 1 = write |
| cp_fin | input | 1 | Control port transaction finished |
| cp_hi_bank | input | 1 | Control port top address bit, 1 = second bank |
| eng_busy | input | 1 | Write engine busy, blocks new grants |
| b1_grant | output | 1 | Bank port 1 may respond |
| b2_grant | output | 1 | Bank port 2 may respond |
| cp_grant | output | 1 | Control port may respond |
| cp_bank_en | output | 2 | Bank enables driven by the control port |
| wr_busy | output | 1 | Internal write interval is being timed |
| comb_mode | output | 1 | Last granted session was on the control port |
| b1_ptr_ok | output | 1 | Bank port 1 address pointer valid |
| b2_ptr_ok | output | 1 | Bank port 2 address pointer valid |
| cp_ptr_ok | output | 1 | Control port address pointer valid |

## Verification
The hardest cases to reach are the handover edges. At such an edge one port's session closes while another port's new request arrives. The grant then moves in the same cycle, and a pointer flag can be set and cleared together. The case where a write session closes while a different port is already waiting also falls here. Directed sequences place a finish strobe and a competing request in the same cycle. A seeded random phase then runs three independent request/finish agents with random session lengths and occasional engine-busy pulses, so that these handovers recur many times against a bench model.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {
    MODE_BANK = 1'b0,
    MODE_COMB = 1'b1
  } mode_e;

  localparam int NPORT  = 3;
  localparam int PI_B1  = 0;
  localparam int PI_B2  = 1;
  localparam int PI_CTL = 2;
endpackage

// File: rtl/arb_grant_logic.sv
module arb_grant_logic
  import arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] req,
  input  logic [NPORT-1:0] wr,
  input  logic [NPORT-1:0] fin,
  input  logic             hold,
  output logic [NPORT-1:0] own,
  output logic [NPORT-1:0] own_wr,
  output logic [NPORT-1:0] start,
  output logic             wr_done
);
  logic [NPORT-1:0] own_q, own_wr_q, own_d, own_wr_d, keep, nw;
  logic             blk;

  always_comb begin
    keep    = own_q & ~fin;
    wr_done = |(own_q & fin & own_wr_q);
    blk     = hold | wr_done;
    nw      = '0;
    // control port: only when no bank session survives this edge
    nw[PI_CTL] = !blk && req[PI_CTL] && !own_q[PI_CTL] && !(|keep[PI_B2:PI_B1]);
    // bank port 1: may share only with a reading bank port 2
    nw[PI_B1] = !blk && req[PI_B1] && !own_q[PI_B1] && !keep[PI_CTL] && !nw[PI_CTL]
                && !(keep[PI_B2] && (own_wr_q[PI_B2] || wr[PI_B1]));
    // bank port 2: same, and yields to a same-cycle port 1 when a write is involved
    nw[PI_B2] = !blk && req[PI_B2] && !own_q[PI_B2] && !keep[PI_CTL] && !nw[PI_CTL]
                && !(keep[PI_B1] && (own_wr_q[PI_B1] || wr[PI_B2]))
                && !(nw[PI_B1] && (wr[PI_B1] || wr[PI_B2]));
    own_d = keep | nw;
    for (int i = 0; i < NPORT; i++) begin
      own_wr_d[i] = nw[i] ? wr[i] : own_wr_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q    <= '0;
      own_wr_q <= '0;
    end else begin
      own_q    <= own_d;
      own_wr_q <= own_wr_d;
    end
  end

  assign own    = own_q;
  assign own_wr = own_wr_q;
  assign start  = nw;
endmodule

// File: rtl/arb_write_timer.sv
module arb_write_timer #(
  parameter int unsigned WR_CYCLES = 625000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  localparam int CW = (WR_CYCLES < 2) ? 1 : $clog2(WR_CYCLES);
  localparam logic [CW-1:0] LOADV = CW'(WR_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load | busy_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (load) begin
      cnt_d  = LOADV;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/arb_mode_track.sv
module arb_mode_track
  import arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] start,
  input  logic [NPORT-1:0] fin,
  input  logic [NPORT-1:0] own,
  output logic             comb,
  output logic [NPORT-1:0] ptr_ok
);
  mode_e            mode_q, mode_d, tgt;
  logic [NPORT-1:0] ptr_q, ptr_d;
  logic             chg;

  always_comb begin
    tgt    = start[PI_CTL] ? MODE_COMB : MODE_BANK;
    chg    = (|start) && (tgt != mode_q);
    mode_d = chg ? tgt : mode_q;
    ptr_d  = ptr_q | (own & fin);
    if (chg) begin
      if (tgt == MODE_COMB) begin
        ptr_d[PI_B1] = 1'b0;
        ptr_d[PI_B2] = 1'b0;
      end else begin
        ptr_d[PI_CTL] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_BANK;
      ptr_q  <= '0;
    end else begin
      mode_q <= mode_d;
      ptr_q  <= ptr_d;
    end
  end

  assign comb   = (mode_q == MODE_COMB);
  assign ptr_ok = ptr_q;
endmodule

// File: rtl/bank_port_arbiter.sv
module bank_port_arbiter
  import arb_pkg::*;
#(
  parameter int unsigned WR_CYCLES = 625000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       b1_req,
  input  logic       b1_wr,
  input  logic       b1_fin,
  input  logic       b2_req,
  input  logic       b2_wr,
  input  logic       b2_fin,
  input  logic       cp_req,
  input  logic       cp_wr,
  input  logic       cp_fin,
  input  logic       cp_hi_bank,
  input  logic       eng_busy,
  output logic       b1_grant,
  output logic       b2_grant,
  output logic       cp_grant,
  output logic [1:0] cp_bank_en,
  output logic       wr_busy,
  output logic       comb_mode,
  output logic       b1_ptr_ok,
  output logic       b2_ptr_ok,
  output logic       cp_ptr_ok
);
  logic [1:0]       rsync;
  logic             rst_i;
  logic [NPORT-1:0] req, wr, fin, own, own_wr, start, ptr;
  logic             wr_done, busy, hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= '0;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_i = rsync[1];

  assign req  = {cp_req, b2_req, b1_req};
  assign wr   = {cp_wr,  b2_wr,  b1_wr};
  assign fin  = {cp_fin, b2_fin, b1_fin};
  assign hold = busy | eng_busy;

  arb_grant_logic u_grant (
    .clk(clk), .rst_n(rst_i), .req(req), .wr(wr), .fin(fin), .hold(hold),
    .own(own), .own_wr(own_wr), .start(start), .wr_done(wr_done)
  );

  arb_write_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_i), .load(wr_done), .busy(busy)
  );

  arb_mode_track u_mode (
    .clk(clk), .rst_n(rst_i), .start(start), .fin(fin), .own(own),
    .comb(comb_mode), .ptr_ok(ptr)
  );

  assign b1_grant   = own[PI_B1];
  assign b2_grant   = own[PI_B2];
  assign cp_grant   = own[PI_CTL];
  assign cp_bank_en = own[PI_CTL] ? (cp_hi_bank ? 2'b10 : 2'b01) : 2'b00;
  assign wr_busy    = busy;
  assign b1_ptr_ok  = ptr[PI_B1];
  assign b2_ptr_ok  = ptr[PI_B2];
  assign cp_ptr_ok  = ptr[PI_CTL];
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int unsigned WR_CYCLES = 625000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       b1_fin,
  input logic       b2_fin,
  input logic       cp_fin,
  input logic       eng_busy,
  input logic       b1_grant,
  input logic       b2_grant,
  input logic       cp_grant,
  input logic [1:0] cp_bank_en,
  input logic       wr_busy,
  input logic       comb_mode,
  input logic       b1_ptr_ok,
  input logic       b2_ptr_ok,
  input logic       cp_ptr_ok,
  input logic [2:0] own_wr
);
  logic [31:0] busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       busy_len <= '0;
    else if (wr_busy) busy_len <= busy_len + 1'b1;
    else              busy_len <= '0;
  end

  p_ctl_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cp_grant |-> (!b1_grant && !b2_grant));

  p_b1_write_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (b1_grant && own_wr[0]) |-> (!b2_grant && !cp_grant));

  p_b2_write_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (b2_grant && own_wr[1]) |-> (!b1_grant && !cp_grant));

  p_busy_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((b1_fin && b1_grant && own_wr[0]) || (b2_fin && b2_grant && own_wr[1]) ||
     (cp_fin && cp_grant && own_wr[2])) |=> wr_busy);

  p_busy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_len <= WR_CYCLES);

  p_no_grant_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(b1_grant) || $rose(b2_grant) || $rose(cp_grant)) |->
      ($past(!wr_busy) && $past(!eng_busy)));

  p_bank_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cp_grant ? ($countones(cp_bank_en) == 1) : (cp_bank_en == 2'b00));

  p_mode_moves_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (comb_mode != $past(comb_mode)) |->
      ($rose(b1_grant) || $rose(b2_grant) || $rose(cp_grant)));

  p_ptr_comb_r11: assert property (@(posedge clk) disable iff (!rst_n)
    comb_mode |-> (!b1_ptr_ok && !b2_ptr_ok));

  p_ptr_bank_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !comb_mode |-> !cp_ptr_ok);
endmodule

bind bank_port_arbiter arb_checker #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .b1_fin(b1_fin), .b2_fin(b2_fin), .cp_fin(cp_fin),
  .eng_busy(eng_busy), .b1_grant(b1_grant), .b2_grant(b2_grant),
  .cp_grant(cp_grant), .cp_bank_en(cp_bank_en), .wr_busy(wr_busy),
  .comb_mode(comb_mode), .b1_ptr_ok(b1_ptr_ok), .b2_ptr_ok(b2_ptr_ok),
  .cp_ptr_ok(cp_ptr_ok), .own_wr(own_wr)
);

// File: tb/sim_bank_port_arbiter.sv
module sim_bank_port_arbiter;
  localparam int unsigned WRC = 24;

  logic       clk, rst_n;
  logic [2:0] req_v, wr_v, fin_v;
  logic       hi_v, eb_v;
  logic       b1_grant, b2_grant, cp_grant, wr_busy, comb_mode;
  logic       b1_ptr_ok, b2_ptr_ok, cp_ptr_ok;
  logic [1:0] cp_bank_en;

  int vectors = 0;
  int fails   = 0;
  bit finished = 0;

  // bench model state
  logic [2:0] m_own, m_wr, m_ptr;
  logic       m_busy, m_comb;
  int         m_left;

  bank_port_arbiter #(.WR_CYCLES(WRC)) u0 (
    .clk(clk), .rst_n(rst_n),
    .b1_req(req_v[0]), .b1_wr(wr_v[0]), .b1_fin(fin_v[0]),
    .b2_req(req_v[1]), .b2_wr(wr_v[1]), .b2_fin(fin_v[1]),
    .cp_req(req_v[2]), .cp_wr(wr_v[2]), .cp_fin(fin_v[2]),
    .cp_hi_bank(hi_v), .eng_busy(eb_v),
    .b1_grant(b1_grant), .b2_grant(b2_grant), .cp_grant(cp_grant),
    .cp_bank_en(cp_bank_en), .wr_busy(wr_busy), .comb_mode(comb_mode),
    .b1_ptr_ok(b1_ptr_ok), .b2_ptr_ok(b2_ptr_ok), .cp_ptr_ok(cp_ptr_ok)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] exp_bank_en(input logic g, input logic hi);
    if (!g) return 2'b00;
    return hi ? 2'b10 : 2'b01;
  endfunction

  // one clock edge of the requirement model, using the inputs applied before the edge
  task automatic model_step();
    logic [2:0] stay, grant_new;
    logic       wdone, blocked, go_comb, switched;
    stay    = m_own & ~fin_v;
    wdone   = |(m_own & fin_v & m_wr);
    blocked = m_busy || eb_v || wdone;                      // R8
    grant_new = 3'b000;
    if (!blocked) begin
      // R5, R6: control port first, only with no bank session left
      if (req_v[2] && !m_own[2] && stay[1:0] == 2'b00) grant_new[2] = 1'b1;
      if (!grant_new[2] && !stay[2]) begin
        // R3, R4: bank ports share only for reads; port 1 wins write ties
        if (req_v[0] && !m_own[0] && !(stay[1] && (m_wr[1] || wr_v[0])))
          grant_new[0] = 1'b1;
        if (req_v[1] && !m_own[1] && !(stay[0] && (m_wr[0] || wr_v[1])) &&
            !(grant_new[0] && (wr_v[0] || wr_v[1])))
          grant_new[1] = 1'b1;
      end
    end
    // R7 timer
    if (wdone) begin
      m_busy = 1'b1;
      m_left = WRC;
    end else if (m_busy) begin
      m_left = m_left - 1;
      if (m_left == 0) m_busy = 1'b0;
    end
    // R10, R11
    m_ptr    = m_ptr | (m_own & fin_v);
    go_comb  = grant_new[2];
    switched = (grant_new != 3'b000) && (go_comb != m_comb);
    if (switched) begin
      if (go_comb) m_ptr[1:0] = 2'b00;
      else         m_ptr[2]   = 1'b0;
      m_comb = go_comb;
    end
    for (int i = 0; i < 3; i++) if (grant_new[i]) m_wr[i] = wr_v[i];
    m_own = stay | grant_new;
  endtask

  task automatic cmp_all();
    chk("R2 grants", {1'b0, cp_grant, b2_grant, b1_grant}, {1'b0, m_own});
    chk("R7 wr_busy", {3'b0, wr_busy}, {3'b0, m_busy});
    chk("R10 comb_mode", {3'b0, comb_mode}, {3'b0, m_comb});
    chk("R11 ptr flags", {1'b0, cp_ptr_ok, b2_ptr_ok, b1_ptr_ok}, {1'b0, m_ptr});
    chk("R9 cp_bank_en", {2'b0, cp_bank_en}, {2'b0, exp_bank_en(m_own[2], hi_v)});
  endtask

  task automatic cycle();
    @(posedge clk);
    #1;
    model_step();
    cmp_all();
  endtask

  task automatic quiet();
    req_v = '0; wr_v = '0; fin_v = '0; eb_v = 1'b0;
  endtask

  task automatic wait_idle();
    quiet();
    for (int k = 0; k < 200 && wr_busy; k++) cycle();
  endtask

  initial begin
    for (int k = 0; k < 150000; k++) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int n;
    int st [3];
    int len [3];
    void'($urandom(32'd20240611));
    quiet();
    hi_v = 1'b0;
    rst_n = 1'b0;
    m_own = '0; m_wr = '0; m_ptr = '0; m_busy = 1'b0; m_comb = 1'b0; m_left = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 reset grants", {1'b0, cp_grant, b2_grant, b1_grant}, 4'h0);
    chk("R1 reset busy/mode", {2'b0, wr_busy, comb_mode}, 4'h0);
    chk("R1 reset ptr", {1'b0, cp_ptr_ok, b2_ptr_ok, b1_ptr_ok}, 4'h0);
    chk("R1 reset bank_en", {2'b0, cp_bank_en}, 4'h0);
    rst_n = 1'b1;
    repeat (3) cycle();

    // R3: simultaneous reads on both bank ports
    req_v = 3'b011; wr_v = 3'b000;
    cycle();
    chk("R3 both reads granted", {2'b0, b2_grant, b1_grant}, 4'h3);
    cycle();
    chk("R2 grants held", {2'b0, b2_grant, b1_grant}, 4'h3);
    req_v = 3'b000; fin_v = 3'b011;
    cycle();
    chk("R2 grants fall on finish", {2'b0, b2_grant, b1_grant}, 4'h0);
    chk("R12 read end leaves busy low", {3'b0, wr_busy}, 4'h0);
    chk("R11 ptr set at end", {2'b0, b2_ptr_ok, b1_ptr_ok}, 4'h3);
    fin_v = '0;
    cycle();

    // R4: write on port 1 excludes port 2 and control
    req_v = 3'b011; wr_v = 3'b001;
    cycle();
    chk("R4 port1 write wins tie", {2'b0, b2_grant, b1_grant}, 4'h1);
    req_v = 3'b111;
    cycle();
    chk("R4 write excludes others", {2'b0, cp_grant, b2_grant}, 4'h0);
    req_v = 3'b010; wr_v = 3'b000; fin_v = 3'b001;
    cycle();
    fin_v = '0;
    chk("R7 busy rises at write end", {3'b0, wr_busy}, 4'h1);
    n = 0;
    while (wr_busy && n < 100) begin
      n++;
      chk("R8 no grant while busy", {3'b0, b2_grant}, 4'h0);
      cycle();
    end
    chk("R7 busy length", 4'(n == WRC), 4'h1);
    chk("R8 still none at release edge", {3'b0, b2_grant}, 4'h0);
    cycle();
    chk("R8 held request granted after busy", {3'b0, b2_grant}, 4'h1);
    req_v = '0; fin_v = 3'b010;
    cycle();
    fin_v = '0;
    cycle();

    // R6: control beats a bank port with nothing active
    req_v = 3'b101; hi_v = 1'b1;
    cycle();
    chk("R6 control wins", {2'b0, cp_grant, b1_grant}, 4'h2);
    chk("R10 comb set", {3'b0, comb_mode}, 4'h1);
    chk("R11 bank ptr cleared", {2'b0, b2_ptr_ok, b1_ptr_ok}, 4'h0);
    chk("R9 high bank", {2'b0, cp_bank_en}, 4'h2);
    hi_v = 1'b0;
    #1;
    chk("R9 low bank", {2'b0, cp_bank_en}, 4'h1);
    // handover: control finishes while port 1 waits
    req_v = 3'b001; fin_v = 3'b100;
    cycle();
    fin_v = '0;
    chk("R5 handover to port 1", {2'b0, cp_grant, b1_grant}, 4'h1);
    chk("R10 comb cleared", {3'b0, comb_mode}, 4'h0);
    chk("R11 clear wins over set", {3'b0, cp_ptr_ok}, 4'h0);
    chk("R9 bank_en idle", {2'b0, cp_bank_en}, 4'h0);
    // R5: control waits for bank session, then excludes bank ports
    req_v = 3'b100; fin_v = 3'b001;
    cycle();
    fin_v = '0;
    chk("R5 control after bank end", {3'b0, cp_grant}, 4'h1);
    req_v = 3'b111;
    cycle();
    chk("R5 banks excluded", {2'b0, b2_grant, b1_grant}, 4'h0);
    req_v = 3'b000; fin_v = 3'b100;
    cycle();
    fin_v = '0;
    chk("R11 control ptr set", {3'b0, cp_ptr_ok}, 4'h1);
    // R8: engine busy blocks
    eb_v = 1'b1; req_v = 3'b010;
    cycle(); cycle();
    chk("R8 engine busy blocks", {3'b0, b2_grant}, 4'h0);
    eb_v = 1'b0;
    cycle();
    chk("R8 granted after engine idle", {3'b0, b2_grant}, 4'h1);
    chk("R11 control ptr dropped", {3'b0, cp_ptr_ok}, 4'h0);
    req_v = '0; fin_v = 3'b010;
    cycle();
    fin_v = '0;
    // control write starts timer too
    req_v = 3'b100; wr_v = 3'b100;
    cycle();
    req_v = '0; fin_v = 3'b100;
    cycle();
    chk("R7 control write busy", {3'b0, wr_busy}, 4'h1);
    wait_idle();
    cycle();

    // seeded random phase against the model
    for (int i = 0; i < 3; i++) begin st[i] = 0; len[i] = 0; end
    for (int c = 0; c < 4000; c++) begin
      fin_v = '0;
      for (int i = 0; i < 3; i++) begin
        case (st[i])
          0: if ($urandom % 5 == 0) begin
               req_v[i] = 1'b1;
               wr_v[i]  = ($urandom % 3 == 0);
               len[i]   = 1 + $urandom % 6;
               st[i]    = 1;
             end
          1: if (m_own[i]) begin
               if (len[i] == 0) begin
                 fin_v[i] = 1'b1; req_v[i] = 1'b0; st[i] = 2;
               end else len[i]--;
             end
          default: st[i] = 0;
        endcase
      end
      hi_v = $urandom % 2;
      eb_v = ($urandom % 20 == 0);
      cycle();
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule